// File: doc/BRIEF.md
# GPIO port controller with atomic set/clear and edge interrupts

This block controls one general-purpose I/O port of `NPINS` pins (16 by default) behind a plain 32-bit register bus. Each access is a one-cycle select strobe with a write flag. Software writes the output latch, the per-pin direction and the per-pin open-drain mode. Two write-only registers let one write set or clear a chosen group of output bits while every other bit keeps its value, so no read-modify-write sequence is needed.

Each pin input passes through a two-flop synchronizer. A rising edge of the synchronized value latches that pin's raw interrupt flag. Software reads the flags at a read-only status register and clears them by writing ones to a dedicated clear register. A per-pin enable mask decides which flags reach the single registered interrupt request. Read data is registered and appears one cycle after the read strobe.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset the output latch, direction, open-drain, enable and raw flag registers are all zero, `pin_oe` is 0 and `irq` is 0.
- R2: A write to offset 0x00 loads the output latch. A read of 0x00 returns the pin inputs after two synchronizer flops, so a change in a pin input is not visible in a read sampled at the next clock edge.
- R3: Direction at offset 0x04 uses 1 for output. With open-drain off, `pin_oe` equals the direction bits.
- R4: Writing offset 0x24 (write-only) sets each latch bit whose write bit is 1 and leaves the latch bits with a 0 write bit unchanged.
- R5: Writing offset 0x28 (write-only) clears each latch bit whose write bit is 1 and leaves the latch bits with a 0 write bit unchanged.
- R6: A rising edge on a synchronized input sets that pin's flag in the read-only raw status at offset 0x1C. A falling edge sets nothing, and writes to 0x1C are ignored.
- R7: Writing 1 to bit x of offset 0x20 clears flag x. A 0 bit has no effect.
- R8: When a new edge and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq` is the OR of the raw flags masked by the enable register at 0x10, registered one cycle.
- R10: Open-drain mode is set per pin at 0x2C and acts only on output pins. An output pin in this mode with latch 1 has `pin_oe` 0. With latch 0 it has `pin_oe` 1 and `pin_out` 0. Input pins keep `pin_out` equal to the latch.
- R11: Reads of 0x20, 0x24 and 0x28 return zero. Bits 31:16 of every register read as zero, and writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output value per pin |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: 16 pins, an 8-bit address and a 32-bit data word. Because the port is narrower than the data word, the bench can write ones into the upper sixteen bits and check that they never read back and never reach the pins. The 8-bit offset space covers every mapped register, so the bench can check the read-as-zero behaviour of the write-only registers. The bench times its reads against the pin inputs to observe the two-flop synchronizer. It also places a clear write on the same clock edge as an edge-detect pulse.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned OFS_DATA = 'h00;
  localparam int unsigned OFS_DIR  = 'h04;
  localparam int unsigned OFS_IEN  = 'h10;
  localparam int unsigned OFS_RAW  = 'h1C;
  localparam int unsigned OFS_ICLR = 'h20;
  localparam int unsigned OFS_BSET = 'h24;
  localparam int unsigned OFS_BCLR = 'h28;
  localparam int unsigned OFS_ODC  = 'h2C;

  typedef enum logic [2:0] {
    LATCH_HOLD,
    LATCH_LOAD,
    LATCH_SET,
    LATCH_CLR
  } latch_op_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] rise
);
  logic [NPINS-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign level = stage2_q;
  assign rise  = stage2_q & ~prev_q;

  // R6: a rise pulse means the level was low one cycle earlier
  p_rise_from_low_r6: assert property (@(posedge clk) disable iff (rst)
    (|rise) |-> ((($past(level) & rise)) == '0));
endmodule

// File: rtl/gpio_irq_flags.sv
module gpio_irq_flags #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] evt,
  input  logic [NPINS-1:0] clr_mask,
  input  logic [NPINS-1:0] ien,
  output logic [NPINS-1:0] raw,
  output logic             irq
);
  logic [NPINS-1:0] raw_q;
  logic             irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~clr_mask) | evt;
      irq_q <= |(raw_q & ien);
    end
  end

  assign raw = raw_q;
  assign irq = irq_q;

  // R6: every edge event leaves its flag set
  p_evt_sets_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((raw & $past(evt)) == $past(evt)));
  // R7: cleared bits without a coincident event drop
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (|clr_mask) |=> ((raw & $past(clr_mask & ~evt)) == '0));
  // R8: event wins over clear
  p_evt_beats_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (|(evt & clr_mask)) |=> ((raw & $past(evt & clr_mask)) == $past(evt & clr_mask)));
  // R9: request only follows an enabled flag
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(raw & ien)));
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  latch_op_e        op,
  input  logic             dir_we,
  input  logic             odc_we,
  input  logic [NPINS-1:0] wval,
  output logic [NPINS-1:0] dout,
  output logic [NPINS-1:0] dir,
  output logic [NPINS-1:0] odc,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  logic [NPINS-1:0] dout_q, dir_q, odc_q;
  logic [NPINS-1:0] dout_n;

  always_comb begin
    case (op)
      LATCH_LOAD: dout_n = wval;
      LATCH_SET:  dout_n = dout_q | wval;
      LATCH_CLR:  dout_n = dout_q & ~wval;
      default:    dout_n = dout_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
      odc_q  <= '0;
    end else begin
      dout_q <= dout_n;
      if (dir_we) dir_q <= wval;
      if (odc_we) odc_q <= wval;
    end
  end

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pad
      logic od_active;
      assign od_active  = dir_q[i] & odc_q[i];
      assign pin_out[i] = od_active ? 1'b0 : dout_q[i];
      assign pin_oe[i]  = dir_q[i] & ~(od_active & dout_q[i]);
    end
  endgenerate

  assign dout = dout_q;
  assign dir  = dir_q;
  assign odc  = odc_q;

  // R2: a load write places the write value in the latch
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (op == LATCH_LOAD) |=> (dout == $past(wval)));
  // R4: set write raises masked bits and keeps the others
  p_set_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (op == LATCH_SET) |=> (((dout & $past(wval)) == $past(wval)) &&
                           ((dout & ~$past(wval)) == ($past(dout) & ~$past(wval)))));
  // R5: clear write drops masked bits and keeps the others
  p_clr_bits_r5: assert property (@(posedge clk) disable iff (rst)
    (op == LATCH_CLR) |=> (((dout & $past(wval)) == '0) &&
                           ((dout & ~$past(wval)) == ($past(dout) & ~$past(wval)))));
  // R3: an input pin is never driven
  p_oe_only_out_r3: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~dir) == '0);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(OFS_ICLR);
  localparam logic [ADDR_W-1:0] A_BSET = ADDR_W'(OFS_BSET);
  localparam logic [ADDR_W-1:0] A_BCLR = ADDR_W'(OFS_BCLR);
  localparam logic [ADDR_W-1:0] A_ODC  = ADDR_W'(OFS_ODC);

  logic             wr_en, rd_en;
  logic [NPINS-1:0] wval;
  logic             unused_wdata_hi;
  latch_op_e        op;
  logic             dir_we, odc_we, ien_we;
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] level, rise, raw, dout, dir, odc;
  logic [NPINS-1:0] ien_q;
  logic [NPINS-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;
  assign wval  = bus_wdata[NPINS-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NPINS];

  always_comb begin
    op = LATCH_HOLD;
    if (wr_en) begin
      case (bus_addr)
        A_DATA:  op = LATCH_LOAD;
        A_BSET:  op = LATCH_SET;
        A_BCLR:  op = LATCH_CLR;
        default: op = LATCH_HOLD;
      endcase
    end
  end

  assign dir_we   = wr_en && (bus_addr == A_DIR);
  assign odc_we   = wr_en && (bus_addr == A_ODC);
  assign ien_we   = wr_en && (bus_addr == A_IEN);
  assign clr_mask = (wr_en && (bus_addr == A_ICLR)) ? wval : '0;

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .level(level), .rise(rise)
  );

  gpio_irq_flags #(.NPINS(NPINS)) u_flags (
    .clk(clk), .rst(rst), .evt(rise), .clr_mask(clr_mask),
    .ien(ien_q), .raw(raw), .irq(irq)
  );

  gpio_out_regs #(.NPINS(NPINS)) u_out (
    .clk(clk), .rst(rst), .op(op), .dir_we(dir_we), .odc_we(odc_we),
    .wval(wval), .dout(dout), .dir(dir), .odc(odc),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) ien_q <= '0;
    else if (ien_we) ien_q <= wval;
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  rd_mux = level;
      A_DIR:   rd_mux = dir;
      A_IEN:   rd_mux = ien_q;
      A_RAW:   rd_mux = raw;
      A_ODC:   rd_mux = odc;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_en) rdata_q <= {{(DATA_W-NPINS){1'b0}}, rd_mux};
    else rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;

  // R11: write-only offsets read as zero
  p_wo_read_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (bus_addr == A_ICLR || bus_addr == A_BSET || bus_addr == A_BCLR))
      |=> (bus_rdata == '0));
  // R11: reserved upper bits never read back
  p_hi_zero_r11: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:NPINS] == '0);
  // R1: outputs are quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!irq && pin_oe == '0));
endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
  localparam int NP = 16;
  localparam logic [7:0] A_DATA = 8'h00, A_DIR = 8'h04, A_IEN = 8'h10,
    A_RAW = 8'h1C, A_ICLR = 8'h20, A_BSET = 8'h24, A_BCLR = 8'h28, A_ODC = 8'h2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // kind: 0 write, 1 read-compare, 2 pin_out compare, 3 pin_oe compare
  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [23:0] tag;
  } vec_t;

  localparam vec_t VECS [0:17] = '{
    '{2'd0, A_DATA, 32'h0000_A5A5, "R2"},
    '{2'd2, 8'h00,  32'h0000_A5A5, "R2"},
    '{2'd0, A_BSET, 32'hFFFF_000F, "R4"},
    '{2'd2, 8'h00,  32'h0000_A5AF, "R4"},
    '{2'd0, A_BCLR, 32'h0000_00F0, "R5"},
    '{2'd2, 8'h00,  32'h0000_A50F, "R5"},
    '{2'd1, A_BSET, 32'h0000_0000, "R11"},
    '{2'd1, A_BCLR, 32'h0000_0000, "R11"},
    '{2'd1, A_ICLR, 32'h0000_0000, "R11"},
    '{2'd0, A_DIR,  32'hFFFF_00FF, "R3"},
    '{2'd1, A_DIR,  32'h0000_00FF, "R3"},
    '{2'd3, 8'h00,  32'h0000_00FF, "R3"},
    '{2'd0, A_ODC,  32'h0000_0F0F, "R10"},
    '{2'd3, 8'h00,  32'h0000_00F0, "R10"},
    '{2'd2, 8'h00,  32'h0000_A500, "R10"},
    '{2'd1, A_ODC,  32'h0000_0F0F, "R10"},
    '{2'd0, A_IEN,  32'h1234_8001, "R11"},
    '{2'd1, A_IEN,  32'h0000_8001, "R11"}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    check("R1 pin_out", 32'(pin_out), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    bread(A_DIR, rd); check("R1 dir", rd, 32'h0);
    bread(A_RAW, rd); check("R1 raw", rd, 32'h0);

    for (int i = 0; i < 18; i++) begin
      case (VECS[i].kind)
        2'd0: bwrite(VECS[i].addr, VECS[i].data);
        2'd1: begin bread(VECS[i].addr, rd); check(string'(VECS[i].tag), rd, VECS[i].data); end
        2'd2: check(string'(VECS[i].tag), 32'(pin_out), VECS[i].data);
        default: check(string'(VECS[i].tag), 32'(pin_oe), VECS[i].data);
      endcase
    end

    bwrite(A_IEN, 32'h0);
    bwrite(A_ODC, 32'h0);
    // R2: synchronizer latency, read sampled at the first edge sees old value
    @(negedge clk);
    pin_in = 16'h00C3; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_DATA;
    @(negedge clk);
    bus_sel = 1'b0;
    check("R2 sync old", bus_rdata, 32'h0);
    repeat (3) @(posedge clk);
    bread(A_DATA, rd); check("R2 sync new", rd, 32'h0000_00C3);
    // R6: rising edges latch flags
    bread(A_RAW, rd); check("R6 raw", rd, 32'h0000_00C3);
    check("R9 irq masked", 32'(irq), 32'h0);
    bwrite(A_RAW, 32'h0);
    bread(A_RAW, rd); check("R6 raw read-only", rd, 32'h0000_00C3);
    // R7: zero bits no effect, one bits clear
    bwrite(A_ICLR, 32'hFFFF_0000);
    bread(A_RAW, rd); check("R7 zero no effect", rd, 32'h0000_00C3);
    bwrite(A_ICLR, 32'h0000_0003);
    bread(A_RAW, rd); check("R7 clear", rd, 32'h0000_00C0);
    // R6: falling edges set nothing
    @(negedge clk) pin_in = 16'h0000;
    repeat (4) @(posedge clk);
    bread(A_RAW, rd); check("R6 fall", rd, 32'h0000_00C0);
    // R9: enable gating
    bwrite(A_IEN, 32'h0001);
    @(posedge clk); @(negedge clk);
    check("R9 disabled flag", 32'(irq), 32'h0);
    bwrite(A_IEN, 32'h0040);
    @(posedge clk); @(negedge clk);
    check("R9 enabled flag", 32'(irq), 32'h1);
    bwrite(A_ICLR, 32'h0040);
    @(posedge clk); @(negedge clk);
    check("R9 after clear", 32'(irq), 32'h0);
    bread(A_RAW, rd); check("R7 partial", rd, 32'h0000_0080);
    // R8: clear coincident with a new edge
    bwrite(A_ICLR, 32'hFFFF);
    @(negedge clk) pin_in = 16'h0100;
    @(posedge clk); @(posedge clk);
    bwrite(A_ICLR, 32'h0000_0100);
    bread(A_RAW, rd); check("R8 event kept", rd, 32'h0000_0100);
    // R1: reset again
    @(negedge clk) begin pin_in = '0; rst = 1'b1; end
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check("R1 re pin_out", 32'(pin_out), 32'h0);
    check("R1 re irq", 32'(irq), 32'h0);
    bread(A_IEN, rd); check("R1 re ien", rd, 32'h0);
    bread(A_RAW, rd); check("R1 re raw", rd, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule